// File: doc/BRIEF.md
# NAND Flash Command and Data Sequencer

This block turns a single 32-bit control word into a sequence of strobes on an 8-bit asynchronous NAND flash bus. The word is typically written by a DMA engine's programmed-I/O path. It sets four things: the operation mode, the kind of bus cycle (data, command latch or address latch), the chip enable and a byte count. The sequencer then runs the whole burst without further help from the requester.

The block has four modes:

- **Write:** bytes are pulled from an input stream and latched into the device with write-enable pulses.
- **Read:** bytes are sampled at the end of each read-enable low phase and pushed to an output stream.
- **Read-and-compare:** the device bytes are checked against bytes from the input stream, and a sticky mismatch flag is raised on any difference.
- **Wait:** the block holds until the synchronised ready/busy line reads high.

In write mode, a command cycle can be followed by address cycles in the same burst, so a command and its address bytes go out from one control word. Strobe low and high widths are set by cycle counts; a count of zero selects two clocks.

Top module: `nand_seq`

## Requirements
- R1: After reset the following hold: every chip enable is high, write and read strobes are high, CLE and ALE are low, and `busy` and `done` are low.
- R2: A write-mode word (bits [25:24]=0) with count N (bits [15:0]) consumes N bytes from the input stream in order. It drives each byte on the data bus while `nand_we_n` is low, and it gives exactly N write pulses.
- R3: Bits [19:17] select the cycle kind: 0 is data (CLE and ALE low), 1 is command (CLE high) and 2 is address (ALE high). CLE and ALE are never high together.
- R4: With bit 16 set and cycle kind 1, the first byte of the burst is a command cycle and every later byte is an address cycle.
- R5: A read-mode word (mode 1) with count N gives N read pulses. It presents the bus value sampled at the end of each `nand_re_n` low phase on `rd_data` with a one-cycle `rd_valid`, in bus order.
- R6: In read-and-compare mode (mode 2), each device byte is compared with the next input-stream byte. `cmp_miss` is high after `done` exactly when a byte differed, and `rd_valid` stays low.
- R7: In wait mode (mode 3), the block stays busy while `nand_rb_n` is low. It passes `nand_rb_n` through two flip-flops, so `done` goes high on the third clock edge after `nand_rb_n` rises.
- R8: The chip-select field starts at bit 20. Only `nand_ce_n[cs]` goes low, and only while `busy` is high.
- R9: The strobe low phase lasts `t_low` clocks and the high phase between consecutive read pulses lasts `t_high` clocks. A value of 0 means 2 clocks.
- R10: `busy` is high from the cycle after a word is accepted until the cycle `done` is high. `done` is a one-cycle pulse, and a control word offered while busy is ignored.
- R11: A byte-mode word with count 0 gives a `done` pulse without any strobe, and `busy` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_valid | input | 1 | Control word offered |
| ctl_word | input | 32 | Control word (mode, chip select, cycle kind, increment, count) |
| t_low | input | TW | Strobe low width in clocks, 0 = 2 |
| t_high | input | TW | Strobe high width in clocks, 0 = 2 |
| busy | output | 1 | Operation in progress (run flag) |
| done | output | 1 | One-cycle completion pulse |
| cmp_miss | output | 1 | Compare mismatch seen in the last operation |
| wr_data | input | 8 | Input stream byte |
| wr_valid | input | 1 | Input stream byte valid |
| wr_ready | output | 1 | Input stream byte taken at this edge when valid |
| rd_data | output | 8 | Output stream byte |
| rd_valid | output | 1 | Output stream byte valid |
| nand_ce_n | output | NCS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Data bus drive value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus sampled value |
| nand_rb_n | input | 1 | Ready (high) / busy (low) from the device |

## Verification
The bench drives a page-read preamble: an incrementing command word carrying 00h and four address bytes, then 30h and a ready wait. This separates the command-to-address switch from fixed command or address bursts. A status read (70h, then one byte with bit 6 set) and a four-byte read at uneven strobe widths show whether data is sampled in order and whether the low and high widths follow their own settings. Matching and mismatching compare bursts, a zero-count word, and a word offered mid-burst isolate the flag, the empty case and the busy lockout.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    M_WRITE = 2'd0,
    M_READ  = 2'd1,
    M_CMP   = 2'd2,
    M_WAIT  = 2'd3
  } mode_e;

  localparam logic [2:0] TGT_DATA = 3'd0;
  localparam logic [2:0] TGT_CMD  = 3'd1;
  localparam logic [2:0] TGT_ADDR = 3'd2;

  function automatic mode_e word_mode(input logic [31:0] w);
    return mode_e'(w[25:24]);
  endfunction

  function automatic logic [2:0] word_target(input logic [31:0] w);
    return w[19:17];
  endfunction

  function automatic logic word_incr(input logic [31:0] w);
    return w[16];
  endfunction

  function automatic logic [15:0] word_count(input logic [31:0] w);
    return w[15:0];
  endfunction

  function automatic logic [2:0] word_cs(input logic [31:0] w);
    return w[22:20];
  endfunction

  // after a command byte with increment set, later bytes become address cycles
  function automatic logic [2:0] next_target(input logic [2:0] t, input logic incr);
    return (incr && t == TGT_CMD) ? TGT_ADDR : t;
  endfunction

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nand_seq_csdec.sv
module nand_seq_csdec #(
  parameter int NCS = 4,
  parameter int CSW = 2
) (
  input  logic           en,
  input  logic [CSW-1:0] sel,
  output logic [NCS-1:0] ce_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_ce
    assign ce_n[i] = !(en && (sel == CSW'(i)));
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int NCS = 4,
  parameter int TW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_valid,
  input  logic [31:0]    ctl_word,
  input  logic [TW-1:0]  t_low,
  input  logic [TW-1:0]  t_high,
  output logic           busy,
  output logic           done,
  output logic           cmp_miss,
  input  logic [7:0]     wr_data,
  input  logic           wr_valid,
  output logic           wr_ready,
  output logic [7:0]     rd_data,
  output logic           rd_valid,
  output logic [NCS-1:0] nand_ce_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [7:0]     nand_dq_o,
  output logic           nand_dq_oe,
  input  logic [7:0]     nand_dq_i,
  input  logic           nand_rb_n
);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOW, S_HIGH, S_WAIT} state_e;

  function automatic logic [TW-1:0] phase_len(input logic [TW-1:0] t);
    return (t == '0) ? TW'(2) : t;
  endfunction

  state_e         state_q, state_d;
  mode_e          mode_q;
  logic [2:0]     tgt_q;
  logic           incr_q;
  logic [15:0]    rem_q;
  logic [CSW-1:0] cs_q;
  logic [7:0]     byte_q, rdd_q;
  logic           miss_q, done_q, rdv_q;
  logic           tmr_zero, tmr_load, rb_ready;
  logic [TW-1:0]  tmr_val;

  // named events
  logic accept, in_wait, in_empty, stream_mode, byte_last;
  logic fetch_take, lo_end, hi_end, wait_ok, enter_low, finish, wait_active;

  assign accept      = (state_q == S_IDLE) && ctl_valid;
  assign in_wait     = word_mode(ctl_word) == M_WAIT;
  assign in_empty    = word_count(ctl_word) == 16'd0;
  assign stream_mode = (mode_q == M_WRITE) || (mode_q == M_CMP);
  assign byte_last   = rem_q == 16'd1;
  assign fetch_take  = (state_q == S_FETCH) && wr_valid;
  assign lo_end      = (state_q == S_LOW)  && tmr_zero;
  assign hi_end      = (state_q == S_HIGH) && tmr_zero;
  assign wait_active = state_q == S_WAIT;
  assign wait_ok     = wait_active && rb_ready;
  assign enter_low   = fetch_take
                     || (accept && !in_wait && !in_empty && word_mode(ctl_word) == M_READ)
                     || (hi_end && !byte_last && mode_q == M_READ);
  assign finish      = (accept && !in_wait && in_empty) || (hi_end && byte_last) || wait_ok;

  assign tmr_load = enter_low || lo_end;
  assign tmr_val  = lo_end ? phase_len(t_high) - 1'b1 : phase_len(t_low) - 1'b1;

  nand_seq_sync u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rb_ready)
  );

  nand_seq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  nand_seq_csdec #(.NCS(NCS), .CSW(CSW)) u_csdec (
    .en(busy), .sel(cs_q), .ce_n(nand_ce_n)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        if (in_wait)                              state_d = S_WAIT;
        else if (in_empty)                        state_d = S_IDLE;
        else if (word_mode(ctl_word) == M_READ)   state_d = S_LOW;
        else                                      state_d = S_FETCH;
      end
      S_FETCH: if (wr_valid) state_d = S_LOW;
      S_LOW:   if (tmr_zero) state_d = S_HIGH;
      S_HIGH:  if (tmr_zero) begin
        if (byte_last)        state_d = S_IDLE;
        else if (stream_mode) state_d = S_FETCH;
        else                  state_d = S_LOW;
      end
      S_WAIT:  if (rb_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= M_WRITE;
      tgt_q   <= TGT_DATA;
      incr_q  <= 1'b0;
      rem_q   <= '0;
      cs_q    <= '0;
      byte_q  <= '0;
      rdd_q   <= '0;
      miss_q  <= 1'b0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      rdv_q   <= lo_end && (mode_q == M_READ);
      if (accept) begin
        mode_q <= word_mode(ctl_word);
        tgt_q  <= word_target(ctl_word);
        incr_q <= word_incr(ctl_word);
        rem_q  <= word_count(ctl_word);
        cs_q   <= CSW'(word_cs(ctl_word));
        miss_q <= 1'b0;
      end
      if (fetch_take) byte_q <= wr_data;
      if (lo_end && mode_q == M_READ) rdd_q <= nand_dq_i;
      if (lo_end && mode_q == M_CMP && nand_dq_i != byte_q) miss_q <= 1'b1;
      if (hi_end && !byte_last) begin
        rem_q <= rem_q - 16'd1;
        tgt_q <= next_target(tgt_q, incr_q);
      end
    end
  end

  assign busy       = state_q != S_IDLE;
  assign done       = done_q;
  assign cmp_miss   = miss_q;
  assign wr_ready   = state_q == S_FETCH;
  assign rd_data    = rdd_q;
  assign rd_valid   = rdv_q;
  assign nand_cle   = busy && !wait_active && tgt_q == TGT_CMD;
  assign nand_ale   = busy && !wait_active && tgt_q == TGT_ADDR;
  assign nand_we_n  = !((state_q == S_LOW) && (mode_q == M_WRITE));
  assign nand_re_n  = !((state_q == S_LOW) && (mode_q == M_READ || mode_q == M_CMP));
  assign nand_dq_o  = byte_q;
  assign nand_dq_oe = busy && (mode_q == M_WRITE);
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic [NCS-1:0] ce_n,
  input logic           cle,
  input logic           ale,
  input logic           we_n,
  input logic           re_n,
  input logic           dq_oe,
  input logic           rd_valid,
  input logic           wait_active,
  input logic           rb_ready,
  input logic           rb_n
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r10_done_idle:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r3_latch_excl:  assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));
  a_r8_ce_single:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ce_n));
  a_r8_ce_idle:     assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (&ce_n));
  a_r2_we_drives:   assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> dq_oe);
  a_r5_rd_in_op:    assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> busy);
  a_r7_wait_hold:   assert property (@(posedge clk) disable iff (!rst_n)
                      (wait_active && !rb_ready) |=> busy);
  a_r7_sync_delay:  assert property (@(posedge clk) disable iff (!rst_n)
                      (wait_active && !rb_n) |=> !done);
endmodule

bind nand_seq nand_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ce_n(nand_ce_n),
  .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
  .dq_oe(nand_dq_oe), .rd_valid(rd_valid), .wait_active(wait_active),
  .rb_ready(rb_ready), .rb_n(nand_rb_n)
);

// File: tb/tb_nand_seq.sv
`timescale 1ns/1ps
module tb_nand_seq;
  localparam int NCS = 4;
  localparam int TW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_valid = 1'b0;
  logic [31:0] ctl_word = '0;
  logic [TW-1:0] t_low = '0, t_high = '0;
  logic busy, done, cmp_miss, wr_ready, rd_valid;
  logic [7:0] wr_data, rd_data, nand_dq_o, nand_dq_i;
  logic wr_valid = 1'b1;
  logic [NCS-1:0] nand_ce_n;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic nand_rb_n = 1'b1;

  always #5 clk = ~clk;

  nand_seq #(.NCS(NCS), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_word(ctl_word),
    .t_low(t_low), .t_high(t_high), .busy(busy), .done(done), .cmp_miss(cmp_miss),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
  );

  int compared = 0, mismatched = 0;
  logic [7:0] src [256];
  logic [7:0] mem [256];
  int wptr = 0, ridx = 0;
  assign wr_data   = src[wptr[7:0]];
  assign nand_dq_i = mem[ridx[7:0]];

  always @(posedge clk) if (wr_ready && wr_valid) wptr <= wptr + 1;
  always @(posedge nand_re_n) ridx <= ridx + 1;

  // bus monitor
  logic [7:0] wl_byte [256];
  logic wl_cle [256], wl_ale [256];
  logic [NCS-1:0] wl_ce [256];
  int wn = 0, cur_we = 0, last_we_lo = 0;
  int cur_re = 0, last_re_lo = 0, cur_gap = 0, last_gap = 0, re_n_cnt = 0;
  bit gap_run = 0;
  logic [7:0] rl [256];
  int rn = 0, busy_seen = 0;

  always @(negedge clk) begin
    if (busy) busy_seen = busy_seen + 1;
    if (!nand_we_n) begin
      if (cur_we == 0) begin
        wl_byte[wn[7:0]] = nand_dq_o; wl_cle[wn[7:0]] = nand_cle;
        wl_ale[wn[7:0]] = nand_ale;   wl_ce[wn[7:0]] = nand_ce_n;
        wn = wn + 1;
      end
      cur_we = cur_we + 1;
    end else if (cur_we != 0) begin
      last_we_lo = cur_we; cur_we = 0;
    end
    if (!nand_re_n) begin
      if (cur_re == 0) re_n_cnt = re_n_cnt + 1;
      if (cur_re == 0 && gap_run) begin last_gap = cur_gap; gap_run = 0; end
      cur_re = cur_re + 1;
    end else begin
      if (cur_re != 0) begin last_re_lo = cur_re; cur_re = 0; gap_run = 1; cur_gap = 0; end
      if (gap_run) cur_gap = cur_gap + 1;
      if (!busy) gap_run = 0;
    end
    if (rd_valid) begin rl[rn[7:0]] = rd_data; rn = rn + 1; end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int mode, input int tgt, input bit incr,
                                     input int cs, input int cnt);
    return {6'd0, 2'(mode), 1'b0, 3'(cs), 3'(tgt), incr, 16'(cnt)};
  endfunction

  // issue a word and wait for done; returns cycles from acceptance to done
  task automatic run_op(input logic [31:0] w, output int cyc);
    cyc = 0;
    @(negedge clk); ctl_word = w; ctl_valid = 1'b1;
    @(negedge clk); ctl_valid = 1'b0;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    if (!done) check("R10", "done timeout", 0, 1);
    @(negedge clk);
    check("R10", "done one cycle", int'(done), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1", "ce_n", int'(nand_ce_n), 'hF);
    check("R1", "we_n/re_n", int'({nand_we_n, nand_re_n}), 3);
    check("R1", "cle/ale", int'({nand_cle, nand_ale}), 0);
    check("R1", "busy/done", int'({busy, done}), 0);
  endtask

  task automatic t_page_preamble();
    int c, base;
    logic [7:0] exp [5] = '{8'h00, 8'h12, 8'h34, 8'h56, 8'h78};
    base = wn;
    for (int k = 0; k < 5; k++) src[(wptr + k) % 256] = exp[k];
    run_op(mk(0, 1, 1'b1, 1, 5), c);
    check("R2", "write pulse count", wn - base, 5);
    for (int k = 0; k < 5; k++) begin
      check("R2", "byte value", int'(wl_byte[base + k]), int'(exp[k]));
      check("R4", "cle", int'(wl_cle[base + k]), k == 0 ? 1 : 0);
      check("R4", "ale", int'(wl_ale[base + k]), k == 0 ? 0 : 1);
      check("R8", "ce_n during strobe", int'(wl_ce[base + k]), 'hD);
    end
    check("R9", "default we low", last_we_lo, 2);
    // confirm command, no increment
    base = wn;
    src[wptr % 256] = 8'h30;
    run_op(mk(0, 1, 1'b0, 3, 1), c);
    check("R3", "confirm cle", int'(wl_cle[base]), 1);
    check("R3", "confirm byte", int'(wl_byte[base]), 'h30);
    check("R8", "ce3", int'(wl_ce[base]), 'h7);
  endtask

  task automatic t_wait_ready();
    nand_rb_n = 1'b0;
    @(negedge clk); ctl_word = mk(3, 0, 1'b0, 0, 0); ctl_valid = 1'b1;
    @(negedge clk); ctl_valid = 1'b0;
    repeat (20) @(negedge clk);
    check("R7", "busy while device busy", int'(busy), 1);
    check("R7", "no done while device busy", int'(done), 0);
    nand_rb_n = 1'b1;
    @(negedge clk); check("R7", "done edge1", int'(done), 0);
    @(negedge clk); check("R7", "done edge2", int'(done), 0);
    @(negedge clk); check("R7", "done edge3", int'(done), 1);
    check("R10", "busy low at done", int'(busy), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_addr_timing();
    int c, base;
    base = wn; t_low = 4'd3; t_high = 4'd1;
    src[wptr % 256] = 8'hA5; src[(wptr + 1) % 256] = 8'h5A;
    run_op(mk(0, 2, 1'b0, 0, 2), c);
    check("R3", "ale cycle", int'({wl_cle[base], wl_ale[base]}), 1);
    check("R3", "ale second", int'(wl_ale[base + 1]), 1);
    check("R9", "we low 3", last_we_lo, 3);
    check("R2", "second byte", int'(wl_byte[base + 1]), 'h5A);
    t_low = '0; t_high = '0;
  endtask

  task automatic t_status_and_read();
    int c, b;
    src[wptr % 256] = 8'h70;
    run_op(mk(0, 1, 1'b0, 0, 1), c);
    mem[ridx % 256] = 8'h40;
    b = rn;
    run_op(mk(1, 0, 1'b0, 0, 1), c);
    check("R5", "status byte count", rn - b, 1);
    check("R5", "status ready bit6", int'(rl[b % 256][6]), 1);
    t_low = 4'd0; t_high = 4'd4;
    for (int k = 0; k < 4; k++) mem[(ridx + k) % 256] = 8'(8'hC0 + k * 7);
    b = rn;
    run_op(mk(1, 0, 1'b0, 2, 4), c);
    check("R5", "read count", rn - b, 4);
    for (int k = 0; k < 4; k++)
      check("R5", "read order", int'(rl[(b + k) % 256]), 'hC0 + k * 7);
    check("R9", "re low default", last_re_lo, 2);
    check("R9", "re high gap", last_gap, 4);
    t_high = '0;
  endtask

  task automatic t_compare();
    int c, b;
    for (int k = 0; k < 3; k++) begin
      mem[(ridx + k) % 256] = 8'(8'h11 * (k + 1));
      src[(wptr + k) % 256] = 8'(8'h11 * (k + 1));
    end
    b = rn;
    run_op(mk(2, 0, 1'b0, 0, 3), c);
    check("R6", "match flag", int'(cmp_miss), 0);
    for (int k = 0; k < 3; k++) begin
      mem[(ridx + k) % 256] = 8'(8'h21 * (k + 1));
      src[(wptr + k) % 256] = (k == 2) ? 8'hEE : 8'(8'h21 * (k + 1));
    end
    run_op(mk(2, 0, 1'b0, 0, 3), c);
    check("R6", "mismatch flag", int'(cmp_miss), 1);
    check("R6", "no rd stream", rn - b, 0);
  endtask

  task automatic t_empty();
    int c, bw, bb;
    bw = wn; bb = busy_seen;
    run_op(mk(0, 0, 1'b0, 0, 0), c);
    check("R11", "no strobes", wn - bw, 0);
    check("R11", "busy never", busy_seen - bb, 0);
  endtask

  task automatic t_ignore();
    int bw, br, dn, cyc;
    bw = wn; br = rn; dn = 0; cyc = 0;
    t_low = 4'd5; t_high = 4'd5;
    for (int k = 0; k < 3; k++) mem[(ridx + k) % 256] = 8'(k + 1);
    @(negedge clk); ctl_word = mk(1, 0, 1'b0, 0, 3); ctl_valid = 1'b1;
    @(negedge clk); ctl_valid = 1'b0;
    check("R10", "busy after accept", int'(busy), 1);
    repeat (3) @(negedge clk);
    ctl_word = mk(0, 0, 1'b0, 1, 2); ctl_valid = 1'b1;
    @(negedge clk); ctl_valid = 1'b0;
    while (cyc < 200) begin
      @(negedge clk); cyc++;
      if (done) dn++;
    end
    check("R10", "one done", dn, 1);
    check("R10", "ignored word wrote nothing", wn - bw, 0);
    check("R10", "read bytes", rn - br, 3);
    t_low = '0; t_high = '0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) begin src[k] = '0; mem[k] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_page_preamble();
    t_wait_ready();
    t_addr_timing();
    t_status_and_read();
    t_compare();
    t_empty();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule